// File: doc/BRIEF.md
# Saturating Multiply-Add Execution Unit

This execution unit handles four signed multiply-accumulate operations that saturate. Each operation receives a 32-bit instruction word and its operand values: two 32-bit sources, an accumulator and the incoming sticky-overflow flag. The accumulator is taken from the low 32 bits of a 64-bit operand port in the narrow forms and from all 64 bits in the wide forms. The unit decodes which operation is present. It selects the multiplier, which is either source B or a sign-extended 9-bit constant taken from the instruction. It then adds the full signed product to the accumulator and clamps the sum to the signed 32-bit or 64-bit range.

Alongside the clamped result the unit reports three status flags, all taken from the unclamped sum: an overflow flag, a sticky overflow flag and an advanced-overflow flag. It also gives the register-file index fields of the instruction. Any word that is not one of the four operations is flagged as illegal, and every write enable is held low for it. The work is split into two registered stages, multiply and then add/saturate/flags. Every accepted operation comes out exactly two cycles later, and a new operation may be accepted in every cycle.

Top module: `sat_mac_unit`

## Requirements
- R1: A word with bits [7:0] = 0x13 is an immediate-form operation. Bits [23:21] = 5 selects the 32-bit result and bits [23:21] = 7 selects the 64-bit result.
- R2: A word with bits [7:0] = 0x03 is a register-form operation that multiplies by src_b. Bits [23:16] = 0x8A selects the 32-bit result and bits [23:16] = 0xEA selects the 64-bit result.
- R3: In the immediate forms the multiplier is bits [20:12] of the word, sign-extended, so 0x1FF multiplies by -1.
- R4: In the 32-bit forms the sum is acc[31:0] plus src_a times the multiplier. The result is clamped to 0x7FFFFFFF or 0x80000000 and placed in result[31:0], with result[63:32] = 0.
- R5: In the 64-bit forms the sum is acc[63:0] plus the full 64-bit product. It is clamped to the signed 64-bit range, and no overflow wraps.
- R6: v_out is 1 exactly when the unclamped sum lies outside the target signed range.
- R7: sv_out is 1 on overflow and otherwise equals the sv_in that was given with the operation.
- R8: av_out is the XOR of bits 31 and 30 of the unclamped sum in 32-bit forms, and the XOR of bits 63 and 62 of it in 64-bit forms.
- R9: carry_we is always 0.
- R10: For any other word, illegal is 1 with out_valid, and res_we, flags_we, result and all three flags are 0. For a legal word, illegal is 0 and res_we and flags_we are 1.
- R11: out_valid is asserted exactly two cycles after in_valid, back-to-back operations are allowed, and out_wide shows the selected result width.
- R12: After reset out_valid is 0.
- R13: dst_idx gives bits [31:28] of the operation, two cycles later with its result. idx_a (bits [11:8]), idx_b (bits [15:12]) and idx_acc (bits [27:24]) are combinational decodes of the current instr.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operation present this cycle |
| instr | input | 32 | Instruction word |
| src_a | input | 32 | Source A value |
| src_b | input | 32 | Source B value (register forms) |
| acc | input | 64 | Accumulator; low half used by 32-bit forms |
| sv_in | input | 1 | Incoming sticky overflow flag |
| idx_a | output | 4 | Source A register index (combinational) |
| idx_b | output | 4 | Source B register index (combinational) |
| idx_acc | output | 4 | Accumulator register index (combinational) |
| out_valid | output | 1 | Result present |
| result | output | 64 | Clamped result |
| out_wide | output | 1 | 1 for a 64-bit result |
| dst_idx | output | 4 | Destination register index |
| res_we | output | 1 | Result write enable |
| flags_we | output | 1 | V/SV/AV write enable |
| v_out | output | 1 | Overflow flag |
| sv_out | output | 1 | Sticky overflow flag |
| av_out | output | 1 | Advanced overflow flag |
| carry_we | output | 1 | Carry write enable, fixed 0 |
| illegal | output | 1 | Unrecognised operation |

## Verification
Every result, flag, write enable and destination index belongs to the operation offered two rising edges earlier, and that is the only latency the design has. The driver offers an operation just after a falling edge and queues the expected item at that point. The monitor samples on falling edges, so an item pushed in cycle n is compared at the falling edge after the second rising edge. The monitor pops one item for each out_valid, so a missing output, a stray output or an output in the wrong cycle shows up as a mismatch or as items left in the queue. The index outputs are combinational and are checked in the same half-cycle as their instruction.

// File: rtl/sat_mac_pkg.sv
package sat_mac_pkg;
  localparam int XLEN  = 32;
  localparam int WLEN  = 2 * XLEN;
  localparam int SLEN  = WLEN + 2;
  localparam int IMM_W = 9;
  localparam int IDX_W = 4;

  localparam logic [7:0] PRI_IMM = 8'h13;
  localparam logic [7:0] PRI_REG = 8'h03;
  localparam logic [2:0] SEC_IMM_N = 3'h5;
  localparam logic [2:0] SEC_IMM_W = 3'h7;
  localparam logic [7:0] SEC_REG_N = 8'h8A;
  localparam logic [7:0] SEC_REG_W = 8'hEA;

  typedef struct packed {
    logic [WLEN-1:0] value;
    logic            ovf;
    logic            adv;
  } sat_res_t;

  function automatic logic [WLEN-1:0] sx_mul(input logic [XLEN-1:0] a, input logic [XLEN-1:0] m);
    logic signed [WLEN-1:0] ea, em;
    ea = $signed({{XLEN{a[XLEN-1]}}, a});
    em = $signed({{XLEN{m[XLEN-1]}}, m});
    return ea * em;
  endfunction

  function automatic logic [SLEN-1:0] wide_add(input logic [WLEN-1:0] x, input logic [WLEN-1:0] y);
    return {{2{x[WLEN-1]}}, x} + {{2{y[WLEN-1]}}, y};
  endfunction

  function automatic sat_res_t clamp_narrow(input logic [SLEN-1:0] s);
    sat_res_t r;
    logic [SLEN-XLEN:0] top;
    top = s[SLEN-1:XLEN-1];
    r.ovf = !((top == '0) || (&top));
    r.adv = s[XLEN-1] ^ s[XLEN-2];
    if (!r.ovf)      r.value = {{XLEN{1'b0}}, s[XLEN-1:0]};
    else if (s[SLEN-1]) r.value = {{XLEN{1'b0}}, 1'b1, {(XLEN-1){1'b0}}};
    else             r.value = {{XLEN{1'b0}}, 1'b0, {(XLEN-1){1'b1}}};
    return r;
  endfunction

  function automatic sat_res_t clamp_wide(input logic [SLEN-1:0] s);
    sat_res_t r;
    logic [2:0] top;
    top = s[SLEN-1:WLEN-1];
    r.ovf = !((top == '0) || (&top));
    r.adv = s[WLEN-1] ^ s[WLEN-2];
    if (!r.ovf)      r.value = s[WLEN-1:0];
    else if (s[SLEN-1]) r.value = {1'b1, {(WLEN-1){1'b0}}};
    else             r.value = {1'b0, {(WLEN-1){1'b1}}};
    return r;
  endfunction
endpackage

// File: rtl/sat_mac_decode.sv
module sat_mac_decode
  import sat_mac_pkg::*;
(
  input  logic [XLEN-1:0]  instr,
  output logic             legal,
  output logic             wide,
  output logic             use_imm,
  output logic [XLEN-1:0]  imm_ext,
  output logic [IDX_W-1:0] f_dst,
  output logic [IDX_W-1:0] f_acc,
  output logic [IDX_W-1:0] f_a,
  output logic [IDX_W-1:0] f_b
);
  logic is_imm_n, is_imm_w, is_reg_n, is_reg_w;

  always_comb begin
    is_imm_n = (instr[7:0] == PRI_IMM) && (instr[23:21] == SEC_IMM_N);
    is_imm_w = (instr[7:0] == PRI_IMM) && (instr[23:21] == SEC_IMM_W);
    is_reg_n = (instr[7:0] == PRI_REG) && (instr[23:16] == SEC_REG_N);
    is_reg_w = (instr[7:0] == PRI_REG) && (instr[23:16] == SEC_REG_W);
    legal    = is_imm_n | is_imm_w | is_reg_n | is_reg_w;
    wide     = is_imm_w | is_reg_w;
    use_imm  = is_imm_n | is_imm_w;
    imm_ext  = {{(XLEN-IMM_W){instr[20]}}, instr[20:12]};
    f_dst    = instr[31:28];
    f_acc    = instr[27:24];
    f_a      = instr[11:8];
    f_b      = instr[15:12];
  end

  always_comb begin
    a_r1_r2_onehot_form: assert ($onehot0({is_imm_n, is_imm_w, is_reg_n, is_reg_w}));
  end
endmodule

// File: rtl/sat_mac_mul_stage.sv
module sat_mac_mul_stage
  import sat_mac_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic             legal,
  input  logic             wide,
  input  logic             use_imm,
  input  logic [XLEN-1:0]  imm_ext,
  input  logic [XLEN-1:0]  src_a,
  input  logic [XLEN-1:0]  src_b,
  input  logic [WLEN-1:0]  acc,
  input  logic             sv_in,
  input  logic [IDX_W-1:0] dst_in,
  output logic             s1_valid,
  output logic             s1_legal,
  output logic             s1_wide,
  output logic [WLEN-1:0]  s1_prod,
  output logic [WLEN-1:0]  s1_acc,
  output logic             s1_sv,
  output logic [IDX_W-1:0] s1_dst
);
  logic [XLEN-1:0] mult_sel;
  logic [WLEN-1:0] acc_sel;

  always_comb begin
    mult_sel = use_imm ? imm_ext : src_b;
    acc_sel  = wide ? acc : {{XLEN{acc[XLEN-1]}}, acc[XLEN-1:0]};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1_valid <= 1'b0;
      s1_legal <= 1'b0;
      s1_wide  <= 1'b0;
      s1_prod  <= '0;
      s1_acc   <= '0;
      s1_sv    <= 1'b0;
      s1_dst   <= '0;
    end else begin
      s1_valid <= in_valid;
      if (in_valid) begin
        s1_legal <= legal;
        s1_wide  <= wide;
        s1_prod  <= sx_mul(src_a, mult_sel);
        s1_acc   <= acc_sel;
        s1_sv    <= sv_in;
        s1_dst   <= dst_in;
      end
    end
  end
endmodule

// File: rtl/sat_mac_sat_stage.sv
module sat_mac_sat_stage
  import sat_mac_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             s1_valid,
  input  logic             s1_legal,
  input  logic             s1_wide,
  input  logic [WLEN-1:0]  s1_prod,
  input  logic [WLEN-1:0]  s1_acc,
  input  logic             s1_sv,
  input  logic [IDX_W-1:0] s1_dst,
  output logic             out_valid,
  output logic [WLEN-1:0]  result,
  output logic             out_wide,
  output logic [IDX_W-1:0] dst_idx,
  output logic             res_we,
  output logic             flags_we,
  output logic             v_out,
  output logic             sv_out,
  output logic             av_out,
  output logic             illegal
);
  logic [SLEN-1:0] raw_sum;
  sat_res_t        clamped;

  always_comb begin
    raw_sum = wide_add(s1_acc, s1_prod);
    clamped = s1_wide ? clamp_wide(raw_sum) : clamp_narrow(raw_sum);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      result    <= '0;
      out_wide  <= 1'b0;
      dst_idx   <= '0;
      res_we    <= 1'b0;
      flags_we  <= 1'b0;
      v_out     <= 1'b0;
      sv_out    <= 1'b0;
      av_out    <= 1'b0;
      illegal   <= 1'b0;
    end else begin
      out_valid <= s1_valid;
      out_wide  <= s1_valid && s1_legal && s1_wide;
      dst_idx   <= s1_dst;
      res_we    <= s1_valid && s1_legal;
      flags_we  <= s1_valid && s1_legal;
      illegal   <= s1_valid && !s1_legal;
      if (s1_valid && s1_legal) begin
        result <= clamped.value;
        v_out  <= clamped.ovf;
        sv_out <= clamped.ovf | s1_sv;
        av_out <= clamped.adv;
      end else begin
        result <= '0;
        v_out  <= 1'b0;
        sv_out <= 1'b0;
        av_out <= 1'b0;
      end
    end
  end

  a_r11_pipe_advance: assert property (@(posedge clk) disable iff (!rst_n)
    s1_valid |=> out_valid);
  a_r10_illegal_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && illegal) |-> (!res_we && !flags_we && result == '0));
  a_r6_v_implies_sv: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && v_out) |-> sv_out);
  a_r4_narrow_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && res_we && !out_wide) |-> (result[WLEN-1:XLEN] == '0));
  a_r7_sticky_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (s1_valid && s1_legal && s1_sv) |=> sv_out);
endmodule

// File: rtl/sat_mac_unit.sv
module sat_mac_unit
  import sat_mac_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [XLEN-1:0]  instr,
  input  logic [XLEN-1:0]  src_a,
  input  logic [XLEN-1:0]  src_b,
  input  logic [WLEN-1:0]  acc,
  input  logic             sv_in,
  output logic [IDX_W-1:0] idx_a,
  output logic [IDX_W-1:0] idx_b,
  output logic [IDX_W-1:0] idx_acc,
  output logic             out_valid,
  output logic [WLEN-1:0]  result,
  output logic             out_wide,
  output logic [IDX_W-1:0] dst_idx,
  output logic             res_we,
  output logic             flags_we,
  output logic             v_out,
  output logic             sv_out,
  output logic             av_out,
  output logic             carry_we,
  output logic             illegal
);
  logic             dec_legal, dec_wide, dec_imm;
  logic [XLEN-1:0]  dec_k;
  logic [IDX_W-1:0] dec_dst;
  logic             s1_valid, s1_legal, s1_wide, s1_sv;
  logic [WLEN-1:0]  s1_prod, s1_acc;
  logic [IDX_W-1:0] s1_dst;

  sat_mac_decode u_dec (
    .instr(instr), .legal(dec_legal), .wide(dec_wide), .use_imm(dec_imm),
    .imm_ext(dec_k), .f_dst(dec_dst), .f_acc(idx_acc), .f_a(idx_a), .f_b(idx_b)
  );

  sat_mac_mul_stage u_mul (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .legal(dec_legal),
    .wide(dec_wide), .use_imm(dec_imm), .imm_ext(dec_k), .src_a(src_a),
    .src_b(src_b), .acc(acc), .sv_in(sv_in), .dst_in(dec_dst),
    .s1_valid(s1_valid), .s1_legal(s1_legal), .s1_wide(s1_wide),
    .s1_prod(s1_prod), .s1_acc(s1_acc), .s1_sv(s1_sv), .s1_dst(s1_dst)
  );

  sat_mac_sat_stage u_sat (
    .clk(clk), .rst_n(rst_n), .s1_valid(s1_valid), .s1_legal(s1_legal),
    .s1_wide(s1_wide), .s1_prod(s1_prod), .s1_acc(s1_acc), .s1_sv(s1_sv),
    .s1_dst(s1_dst), .out_valid(out_valid), .result(result),
    .out_wide(out_wide), .dst_idx(dst_idx), .res_we(res_we),
    .flags_we(flags_we), .v_out(v_out), .sv_out(sv_out), .av_out(av_out),
    .illegal(illegal)
  );

  assign carry_we = 1'b0;

  a_r9_no_carry: assert property (@(posedge clk) disable iff (!rst_n) !carry_we);
  a_r10_we_pairing: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (res_we != illegal) && (flags_we == res_we));
  a_r12_idle_after_reset: assert property (@(posedge clk)
    !rst_n |=> !out_valid);
endmodule

// File: tb/tb_sat_mac_unit.sv
`timescale 1ns/1ps
module tb_sat_mac_unit;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic [31:0] instr = '0, src_a = '0, src_b = '0;
  logic [63:0] acc = '0;
  logic sv_in = 1'b0;
  logic [3:0] idx_a, idx_b, idx_acc, dst_idx;
  logic out_valid, out_wide, res_we, flags_we, v_out, sv_out, av_out, carry_we, illegal;
  logic [63:0] result;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  sat_mac_unit dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .instr(instr),
    .src_a(src_a), .src_b(src_b), .acc(acc), .sv_in(sv_in),
    .idx_a(idx_a), .idx_b(idx_b), .idx_acc(idx_acc), .out_valid(out_valid),
    .result(result), .out_wide(out_wide), .dst_idx(dst_idx), .res_we(res_we),
    .flags_we(flags_we), .v_out(v_out), .sv_out(sv_out), .av_out(av_out),
    .carry_we(carry_we), .illegal(illegal)
  );

  typedef struct {
    logic [63:0] res;
    logic        wide, we, v, sv, av, ill;
    logic [3:0]  dst;
    string       tag;
  } exp_t;

  exp_t sb[$];

  function automatic logic [31:0] enc_imm(input logic [2:0] sec, input logic [3:0] c,
                                          input logic [3:0] d, input logic [3:0] a,
                                          input logic [8:0] k);
    return {c, d, sec, k, a, 8'h13};
  endfunction

  function automatic logic [31:0] enc_reg(input logic [7:0] sec, input logic [3:0] c,
                                          input logic [3:0] d, input logic [3:0] a,
                                          input logic [3:0] b);
    return {c, d, sec, b, a, 8'h03};
  endfunction

  function automatic exp_t model(input logic [31:0] w, input logic [31:0] a,
                                 input logic [31:0] b, input logic [63:0] ac,
                                 input logic s, input string tag);
    exp_t e;
    logic signed [127:0] ma, mm, ma_acc, sum, hi, lo;
    logic is_w, ok, imm;
    imm  = (w[7:0] == 8'h13);
    ok   = (imm && (w[23:21] == 3'd5 || w[23:21] == 3'd7)) ||
           (w[7:0] == 8'h03 && (w[23:16] == 8'h8A || w[23:16] == 8'hEA));
    is_w = imm ? (w[23:21] == 3'd7) : (w[23:16] == 8'hEA);
    ma   = $signed({{96{a[31]}}, a});
    mm   = imm ? $signed({{119{w[20]}}, w[20:12]}) : $signed({{96{b[31]}}, b});
    ma_acc = is_w ? $signed({{64{ac[63]}}, ac}) : $signed({{96{ac[31]}}, ac[31:0]});
    sum  = ma_acc + ma * mm;
    hi   = is_w ? $signed({65'd0, {63{1'b1}}}) : $signed({97'd0, {31{1'b1}}});
    lo   = -hi - 1;
    e.tag = tag;
    e.dst = w[31:28];
    e.ill = !ok;
    e.we  = ok;
    e.wide = ok && is_w;
    if (!ok) begin
      e.res = '0; e.v = 0; e.sv = 0; e.av = 0;
    end else begin
      e.v  = (sum > hi) || (sum < lo);
      e.sv = e.v | s;
      e.av = is_w ? (sum[63] ^ sum[62]) : (sum[31] ^ sum[30]);
      if (sum > hi)      e.res = is_w ? hi[63:0] : {32'd0, hi[31:0]};
      else if (sum < lo) e.res = is_w ? lo[63:0] : {32'd0, lo[31:0]};
      else               e.res = is_w ? sum[63:0] : {32'd0, sum[31:0]};
    end
    return e;
  endfunction

  task automatic push(input logic [31:0] w, input logic [31:0] a, input logic [31:0] b,
                      input logic [63:0] ac, input logic s, input string tag);
    in_valid = 1'b1; instr = w; src_a = a; src_b = b; acc = ac; sv_in = s;
    sb.push_back(model(w, a, b, ac, s, tag));
    #1;
    checks++;
    if (idx_a != w[11:8] || idx_b != w[15:12] || idx_acc != w[27:24]) begin
      errors++;
      $display("FAIL R13 index fields got %h/%h/%h exp %h/%h/%h",
               idx_a, idx_b, idx_acc, w[11:8], w[15:12], w[27:24]);
    end
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      checks++;
      if (sb.size() == 0) begin
        errors++;
        $display("FAIL R11 unexpected out_valid got 1 exp 0");
      end else begin
        exp_t e;
        e = sb.pop_front();
        if (result !== e.res || out_wide !== e.wide || res_we !== e.we ||
            flags_we !== e.we || v_out !== e.v || sv_out !== e.sv ||
            av_out !== e.av || illegal !== e.ill || dst_idx !== e.dst || carry_we !== 1'b0) begin
          errors++;
          $display("FAIL %s got res=%h w=%b we=%b/%b v=%b sv=%b av=%b ill=%b dst=%h cwe=%b exp res=%h w=%b we=%b v=%b sv=%b av=%b ill=%b dst=%h cwe=0",
                   e.tag, result, out_wide, res_we, flags_we, v_out, sv_out, av_out, illegal,
                   dst_idx, carry_we, e.res, e.wide, e.we, e.v, e.sv, e.av, e.ill, e.dst);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    checks++;
    if (out_valid !== 1'b0 || res_we !== 1'b0) begin
      errors++;
      $display("FAIL R12 reset state got valid=%b we=%b exp 0 0", out_valid, res_we);
    end
    // R1 R3 R4 immediate narrow, positive and -1 constant
    push(enc_imm(3'd5, 4'h3, 4'h1, 4'h2, 9'd7), 32'd100, 32'h0, 64'd5, 1'b0, "R1 R3 imm32 basic");
    push(enc_imm(3'd5, 4'h4, 4'h1, 4'h2, 9'h1FF), 32'd100, 32'h0, 64'hFFFF_FFFF_0000_0064, 1'b0, "R3 imm32 minus one, upper acc ignored");
    // R2 R4 R6 register narrow overflow both ways
    push(enc_reg(8'h8A, 4'h5, 4'h1, 4'h2, 4'h3), 32'h4000_0000, 32'd4, 64'd0, 1'b0, "R4 R6 reg32 positive clamp");
    push(enc_reg(8'h8A, 4'h6, 4'h1, 4'h2, 4'h3), 32'h8000_0000, 32'd1, 64'hFFFF_FFFF, 1'b0, "R4 R6 reg32 negative clamp");
    // R8 advanced overflow without overflow
    push(enc_reg(8'h8A, 4'h7, 4'h1, 4'h2, 4'h3), 32'h2000_0000, 32'd2, 64'd0, 1'b0, "R8 reg32 av set");
    // R7 sticky preserved and set
    push(enc_imm(3'd5, 4'h8, 4'h1, 4'h2, 9'd1), 32'd1, 32'h0, 64'd1, 1'b1, "R7 sticky kept");
    push(enc_imm(3'd5, 4'h9, 4'h1, 4'h2, 9'h0FF), 32'h7FFF_FFFF, 32'h0, 64'd0, 1'b0, "R7 sticky raised by overflow");
    // R1 R5 immediate wide
    push(enc_imm(3'd7, 4'hA, 4'h1, 4'h2, 9'h100), 32'h1234_5678, 32'h0, 64'h0000_0001_0000_0000, 1'b0, "R1 R5 imm64 basic");
    // R2 R5 R6 register wide overflow both ways
    push(enc_reg(8'hEA, 4'hB, 4'h1, 4'h2, 4'h3), 32'h7FFF_FFFF, 32'h7FFF_FFFF, 64'h7FFF_FFFF_FFFF_FFFF, 1'b0, "R5 R6 reg64 positive clamp");
    push(enc_reg(8'hEA, 4'hC, 4'h1, 4'h2, 4'h3), 32'h8000_0000, 32'h7FFF_FFFF, 64'h8000_0000_0000_0000, 1'b0, "R5 R6 reg64 negative clamp");
    push(enc_reg(8'hEA, 4'hD, 4'h1, 4'h2, 4'h3), 32'h8000_0000, 32'h8000_0000, 64'h0, 1'b0, "R8 reg64 av from max product");
    // R10 illegal words
    push(enc_imm(3'd1, 4'hE, 4'h1, 4'h2, 9'd3), 32'd9, 32'd9, 64'd9, 1'b1, "R10 illegal imm secondary");
    push(enc_reg(8'h8B, 4'hF, 4'h1, 4'h2, 4'h3), 32'd9, 32'd9, 64'd9, 1'b1, "R10 illegal reg secondary");
    push(32'h1234_56FF, 32'd9, 32'd9, 64'd9, 1'b0, "R10 illegal primary");
    // R11 R13 back-to-back stream
    for (int i = 0; i < 8; i++) begin
      push(enc_reg((i % 2) ? 8'hEA : 8'h8A, 4'(i), 4'h1, 4'(i + 2), 4'(i + 5)),
           32'h0100_0000 * (i + 1), 32'hFFFF_FF00 + 32'(i), 64'h0000_0007_0000_0000 + 64'(i), 1'(i % 3 == 0),
           "R11 R13 back-to-back");
    end
    repeat (4) @(negedge clk);
    checks++;
    if (sb.size() != 0) begin
      errors++;
      $display("FAIL R11 missing outputs got %0d left exp 0", sb.size());
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule